// File: doc/BRIEF.md
# Byte Framer with XOR Checksum

This block is the byte-level packet layer placed on top of a bit-oriented serial link. Its transmit side accepts a payload as a byte stream (the final byte is marked) and emits an encoded frame: an opening delimiter, the payload, a one-byte check value and a closing delimiter. Any payload or check byte that collides with a control value is preceded by an escape byte.

The receive side watches the incoming encoded byte stream. It removes delimiters and escapes, keeps the decoded bytes in an internal bounded store and tests the check value when the closing delimiter arrives. A frame that passes is replayed on the output stream, with its check byte removed. A frame that fails the check, is too short or overruns the store is discarded, and a one-cycle error pulse is raised instead. Every stream uses a valid/ready handshake, and a byte moves on a clock edge where both are high.

Control values: the delimiter is 0x7E, the escape is 0x1B, and the check value starts at 0xAA.

Top module: `byte_framer`

## Requirements
- R1: Out of reset, tx_out_valid, rx_out_valid, rx_done and rx_err are 0, tx_in_ready is 0 and rx_in_ready is 1.
- R2: Each transmitted frame is 0x7E, then the encoded payload bytes in order, then the encoded check byte, then 0x7E, where the final payload byte is the one accepted with tx_in_last=1.
- R3: The transmitted check byte equals 0xAA XORed with every payload byte of the frame.
- R4: A payload or check byte equal to 0x7E or 0x1B is sent as 0x1B followed by the byte itself. The inserted 0x1B does not enter the check value.
- R5: On receive, a 0x7E that is not preceded by an escape always starts a new frame. If it closes a frame with at least 2 stored bytes whose XOR with 0xAA is zero, rx_done pulses for one cycle and all stored bytes except the last are delivered in order, with rx_out_last=1 on the final one.
- R6: On receive, an unescaped 0x1B is neither stored nor folded into the check value. The byte after it is stored and folded literally, even when it is 0x7E or 0x1B.
- R7: A closing delimiter with at least 2 stored bytes and a non-zero check result pulses rx_err and delivers nothing.
- R8: A frame may store up to MAX_LEN+1 bytes (payload plus check byte) and is still delivered. The byte that would be stored beyond that limit ends reception, pulses rx_err and discards the partial frame.
- R9: Bytes received while no frame is open (after reset or after an overrun) are ignored until the next 0x7E.
- R10: While a frame is being delivered, rx_in_ready is 0.
- R11: While tx_out_valid or rx_out_valid is high and its ready is low, the valid stays high and the data stays stable on the next cycle.
- R12: A delimiter that closes a frame with no stored bytes restarts silently. One that closes a frame with exactly one stored byte pulses rx_err.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_in_data | input | 8 | Payload byte to send |
| tx_in_valid | input | 1 | Payload byte available |
| tx_in_last | input | 1 | Marks the final payload byte |
| tx_in_ready | output | 1 | Payload byte accepted this cycle |
| tx_out_data | output | 8 | Encoded byte to the link |
| tx_out_valid | output | 1 | Encoded byte available |
| tx_out_ready | input | 1 | Link accepts the encoded byte |
| rx_in_data | input | 8 | Encoded byte from the link |
| rx_in_valid | input | 1 | Encoded byte available |
| rx_in_ready | output | 1 | Encoded byte accepted |
| rx_out_data | output | 8 | Decoded payload byte |
| rx_out_valid | output | 1 | Decoded byte available |
| rx_out_last | output | 1 | Final byte of a delivered frame |
| rx_out_ready | input | 1 | Consumer accepts the decoded byte |
| rx_done | output | 1 | One-cycle pulse: frame passed its check |
| rx_err | output | 1 | One-cycle pulse: frame dropped |

## Verification
The hardest receive case to reach is the edge of the store: a frame that fills all MAX_LEN+1 slots must still pass, and the next stored byte must abort it. The stimulus drives a 200-byte payload and then a longer run with no delimiter. It follows that run with stray bytes and a fresh frame, which shows that the aborted state ignores input until a delimiter arrives. Escape handling is driven with payloads that hold the control values and with a payload chosen so that the check byte itself is 0x7E.

// File: rtl/byte_framer.sv
module byte_framer #(
  parameter int MAX_LEN = 200,
  parameter logic [7:0] FLAG = 8'h7E,
  parameter logic [7:0] ESC = 8'h1B,
  parameter logic [7:0] CK_INIT = 8'hAA
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] tx_in_data,
  input  logic       tx_in_valid,
  input  logic       tx_in_last,
  output logic       tx_in_ready,
  output logic [7:0] tx_out_data,
  output logic       tx_out_valid,
  input  logic       tx_out_ready,
  input  logic [7:0] rx_in_data,
  input  logic       rx_in_valid,
  output logic       rx_in_ready,
  output logic [7:0] rx_out_data,
  output logic       rx_out_valid,
  output logic       rx_out_last,
  input  logic       rx_out_ready,
  output logic       rx_done,
  output logic       rx_err
);
  localparam int DEPTH = MAX_LEN + 1;
  localparam int AW = $clog2(DEPTH + 1);

  // ---------------- transmit ----------------
  typedef enum logic [2:0] {T_IDLE, T_OPEN, T_DATA, T_LIT, T_CK, T_CLOSE} tx_st_t;
  tx_st_t     tx_st;
  logic [7:0] tx_ck, tx_hold;
  logic       tx_hold_last, tx_hold_ck;

  wire in_sp  = (tx_in_data == FLAG) || (tx_in_data == ESC);
  wire ck_sp  = (tx_ck == FLAG) || (tx_ck == ESC);
  wire tx_fire = tx_out_valid && tx_out_ready;

  assign tx_in_ready = (tx_st == T_DATA) && tx_out_ready;

  always_comb begin
    tx_out_valid = 1'b1;
    tx_out_data  = FLAG;
    case (tx_st)
      T_IDLE:  tx_out_valid = 1'b0;
      T_DATA:  begin tx_out_valid = tx_in_valid; tx_out_data = in_sp ? ESC : tx_in_data; end
      T_LIT:   tx_out_data = tx_hold;
      T_CK:    tx_out_data = ck_sp ? ESC : tx_ck;
      default: tx_out_data = FLAG;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_st <= T_IDLE;
      tx_ck <= CK_INIT;
      tx_hold <= '0;
      tx_hold_last <= 1'b0;
      tx_hold_ck <= 1'b0;
    end else begin
      case (tx_st)
        T_IDLE: if (tx_in_valid) begin tx_st <= T_OPEN; tx_ck <= CK_INIT; end
        T_OPEN: if (tx_fire) tx_st <= T_DATA;
        T_DATA: if (tx_fire) begin
          tx_ck <= tx_ck ^ tx_in_data;
          if (in_sp) begin
            tx_hold <= tx_in_data;
            tx_hold_last <= tx_in_last;
            tx_hold_ck <= 1'b0;
            tx_st <= T_LIT;
          end else begin
            tx_st <= tx_in_last ? T_CK : T_DATA;
          end
        end
        T_LIT: if (tx_fire) tx_st <= tx_hold_ck ? T_CLOSE : (tx_hold_last ? T_CK : T_DATA);
        T_CK: if (tx_fire) begin
          if (ck_sp) begin
            tx_hold <= tx_ck;
            tx_hold_ck <= 1'b1;
            tx_st <= T_LIT;
          end else begin
            tx_st <= T_CLOSE;
          end
        end
        T_CLOSE: if (tx_fire) tx_st <= T_IDLE;
        default: tx_st <= T_IDLE;
      endcase
    end
  end

  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    tx_out_valid && !tx_out_ready |=> tx_out_valid && $stable(tx_out_data)); // R11

  // ---------------- receive ----------------
  logic [7:0]    mem [DEPTH];
  logic          rx_on, rx_esc, rx_drain;
  logic [AW-1:0] rx_len, rx_cnt, rx_rd;
  logic [7:0]    rx_ck;

  wire rx_acc  = rx_in_valid && rx_in_ready;
  wire is_flag = (rx_in_data == FLAG) && !rx_esc;
  wire is_esc  = (rx_in_data == ESC) && !rx_esc;
  wire full    = (rx_len == AW'(DEPTH));
  wire rx_wr   = rx_acc && rx_on && !is_flag && !is_esc && !full;
  wire out_fire = rx_out_valid && rx_out_ready;

  assign rx_in_ready  = !rx_drain;
  assign rx_out_valid = rx_drain;
  assign rx_out_data  = mem[rx_rd];
  assign rx_out_last  = (rx_rd == rx_cnt - AW'(1));

  always_ff @(posedge clk) begin
    if (rx_wr) mem[rx_len] <= rx_in_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_on <= 1'b0;
      rx_esc <= 1'b0;
      rx_drain <= 1'b0;
      rx_len <= '0;
      rx_cnt <= '0;
      rx_rd <= '0;
      rx_ck <= CK_INIT;
      rx_done <= 1'b0;
      rx_err <= 1'b0;
    end else begin
      rx_done <= 1'b0;
      rx_err <= 1'b0;
      if (rx_acc && is_flag) begin
        if (rx_on && rx_len != '0) begin
          if (rx_len >= AW'(2) && rx_ck == 8'h00) begin
            rx_done <= 1'b1;
            rx_drain <= 1'b1;
            rx_rd <= '0;
            rx_cnt <= rx_len - AW'(1);
          end else begin
            rx_err <= 1'b1;
          end
        end
        rx_on <= 1'b1;
        rx_esc <= 1'b0;
        rx_len <= '0;
        rx_ck <= CK_INIT;
      end else if (rx_acc && rx_on) begin
        if (is_esc) begin
          rx_esc <= 1'b1;
        end else if (full) begin
          rx_on <= 1'b0;
          rx_esc <= 1'b0;
          rx_err <= 1'b1;
        end else begin
          rx_esc <= 1'b0;
          rx_len <= rx_len + AW'(1);
          rx_ck <= rx_ck ^ rx_in_data;
        end
      end
      if (out_fire) begin
        if (rx_out_last) rx_drain <= 1'b0;
        else rx_rd <= rx_rd + AW'(1);
      end
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    rx_len <= AW'(DEPTH)); // R8
  AST_DONE_STARTS_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |-> rx_out_valid && rx_out_data == mem[0]); // R5
  AST_ERR_NO_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    rx_err |-> !rx_out_valid && !rx_done); // R7
  AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rx_out_valid && !rx_out_ready |=> rx_out_valid && $stable(rx_out_data) && $stable(rx_out_last)); // R11
endmodule

// File: tb/byte_framer_tb_top.sv
module byte_framer_tb_top;
  localparam int CLK_P = 10;
  typedef logic [7:0] bq_t[$];

  logic clk = 0, rst_n = 0;
  logic [7:0] tx_in_data = 0, rx_in_data = 0;
  logic tx_in_valid = 0, tx_in_last = 0, tx_out_ready = 0;
  logic rx_in_valid = 0, rx_out_ready = 1;
  logic tx_in_ready, tx_out_valid, rx_in_ready, rx_out_valid, rx_out_last, rx_done, rx_err;
  logic [7:0] tx_out_data, rx_out_data;

  int n_chk = 0, n_fail = 0;
  int done_cnt = 0, err_cnt = 0, last_cnt = 0;
  logic [7:0] got_q[$];
  logic [7:0] cap_q[$];
  bit slow_tx = 0;

  always #(CLK_P/2) clk = ~clk;

  byte_framer dut_i (.*);

  always @(posedge clk) if (rst_n) begin
    if (rx_out_valid && rx_out_ready) begin
      got_q.push_back(rx_out_data);
      if (rx_out_last) last_cnt++;
    end
    if (rx_done) done_cnt++;
    if (rx_err) err_cnt++;
    if (tx_out_valid && tx_out_ready) cap_q.push_back(tx_out_data);
  end

  always @(negedge clk) tx_out_ready <= slow_tx ? ~tx_out_ready : 1'b1;

  task automatic check(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic void put_enc(ref bq_t q, input logic [7:0] b);
    if (b == 8'h7E || b == 8'h1B) q.push_back(8'h1B);
    q.push_back(b);
  endfunction

  function automatic bq_t encode(bq_t p);
    bq_t q;
    logic [7:0] ck = 8'hAA;
    q.push_back(8'h7E);
    foreach (p[i]) begin ck ^= p[i]; put_enc(q, p[i]); end
    put_enc(q, ck);
    q.push_back(8'h7E);
    return q;
  endfunction

  task automatic rx_put(logic [7:0] b);
    @(negedge clk);
    rx_in_valid = 1; rx_in_data = b;
    do @(posedge clk); while (!rx_in_ready);
  endtask

  task automatic rx_idle(int n);
    @(negedge clk); rx_in_valid = 0;
    repeat (n) @(negedge clk);
  endtask

  task automatic rx_send(bq_t q);
    foreach (q[i]) rx_put(q[i]);
    rx_idle(260);
  endtask

  task automatic rx_expect(bq_t exp, int ed, int ee, string tag);
    check(got_q.size() == exp.size(), {tag, " count"}, got_q.size(), exp.size());
    for (int i = 0; i < exp.size() && i < got_q.size(); i++)
      check(got_q[i] == exp[i], {tag, " data"}, got_q[i], exp[i]);
    check(done_cnt == ed, {tag, " done"}, done_cnt, ed);
    check(err_cnt == ee, {tag, " err"}, err_cnt, ee);
    check(last_cnt == ed, {tag, " last"}, last_cnt, ed);
    got_q.delete(); done_cnt = 0; err_cnt = 0; last_cnt = 0;
  endtask

  task automatic tx_frame(bq_t p, string tag);
    bq_t exp = encode(p);
    cap_q.delete();
    foreach (p[i]) begin
      @(negedge clk);
      tx_in_valid = 1; tx_in_data = p[i]; tx_in_last = (i == p.size() - 1);
      do @(posedge clk); while (!(tx_in_ready));
    end
    @(negedge clk); tx_in_valid = 0; tx_in_last = 0;
    repeat (40) @(negedge clk);
    check(cap_q.size() == exp.size(), {tag, " length"}, cap_q.size(), exp.size());
    for (int i = 0; i < exp.size() && i < cap_q.size(); i++)
      check(cap_q[i] == exp[i], {tag, " byte"}, cap_q[i], exp[i]);
    check(tx_out_valid == 0, {tag, " idle after frame"}, tx_out_valid, 0);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check(tx_out_valid == 0 && rx_out_valid == 0, "R1 valids", {tx_out_valid, rx_out_valid}, 0);
    check(rx_done == 0 && rx_err == 0, "R1 pulses", {rx_done, rx_err}, 0);
    check(tx_in_ready == 0 && rx_in_ready == 1, "R1 readies", {tx_in_ready, rx_in_ready}, 1);
  endtask

  task automatic t_tx_plain;
    tx_frame('{8'h01, 8'h02, 8'h03}, "R2 R3 plain frame");
    tx_frame('{8'h5A}, "R2 R3 single byte");
  endtask

  task automatic t_tx_escape;
    slow_tx = 1;
    tx_frame('{8'h7E, 8'h1B, 8'h55}, "R4 R11 payload escapes");
    tx_frame('{8'hD4}, "R4 check byte escaped");
    slow_tx = 0;
  endtask

  task automatic t_rx_good;
    rx_send(encode('{8'h10, 8'h20, 8'h30}));
    rx_expect('{8'h10, 8'h20, 8'h30}, 1, 0, "R5 good frame");
  endtask

  task automatic t_rx_escape;
    rx_send(encode('{8'h7E, 8'h1B, 8'h41}));
    rx_expect('{8'h7E, 8'h1B, 8'h41}, 1, 0, "R6 escaped bytes");
  endtask

  task automatic t_rx_bad;
    rx_send('{8'h7E, 8'h10, 8'h20, 8'h33, 8'h7E});
    rx_expect('{}, 0, 1, "R7 bad check");
  endtask

  task automatic t_rx_max;
    bq_t p;
    for (int i = 0; i < 200; i++) p.push_back(8'(i + 1) == 8'h7E ? 8'h01 : 8'(i + 1));
    rx_send(encode(p));
    rx_expect(p, 1, 0, "R8 full length");
  endtask

  task automatic t_rx_overrun;
    rx_put(8'h7E);
    for (int i = 0; i < 205; i++) rx_put(8'h11);
    rx_put(8'h22); rx_put(8'hAA); rx_put(8'h22);
    rx_idle(4);
    check(err_cnt == 1, "R8 overrun err", err_cnt, 1);
    rx_send(encode('{8'h66, 8'h77}));
    rx_expect('{8'h66, 8'h77}, 1, 1, "R8 R9 after overrun");
  endtask

  task automatic t_rx_busy;
    logic [7:0] d0;
    rx_out_ready = 0;
    rx_send(encode('{8'h31, 8'h32}));
    check(rx_in_ready == 0, "R10 input held during delivery", rx_in_ready, 0);
    d0 = rx_out_data;
    @(negedge clk);
    check(rx_out_valid == 1 && rx_out_data == d0, "R11 output held", rx_out_data, d0);
    rx_out_ready = 1;
    repeat (5) @(negedge clk);
    check(rx_in_ready == 1, "R10 input ready after delivery", rx_in_ready, 1);
    rx_expect('{8'h31, 8'h32}, 1, 0, "R10 delivered");
  endtask

  task automatic t_rx_short;
    rx_send('{8'h7E, 8'h7E, 8'h7E});
    rx_expect('{}, 0, 0, "R12 empty frames silent");
    rx_send('{8'h7E, 8'hAA, 8'h7E});
    rx_expect('{}, 0, 1, "R12 one stored byte");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_tx_plain();
    t_tx_escape();
    t_rx_good();
    t_rx_escape();
    t_rx_bad();
    t_rx_max();
    t_rx_overrun();
    t_rx_busy();
    t_rx_short();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(CLK_P * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule